// File: doc/BRIEF.md
# Single-Bank DRAM Command Sequencer

This block sits between a memory client and one DRAM bank. It accepts read and write requests, each carrying a row and a column address, over a valid/ready handshake. It turns every request into the shortest legal command sequence for the current row state. It keeps the last opened row open. A request to that row goes straight to a column command. A request to a closed bank first opens the row. A request to any other row first closes the open row and then opens the new one.

Four timing values are runtime inputs, all counted in memory clock cycles: the read latency (CL), the activate-to-column gap (tRCD), the precharge recovery (tRP) and the minimum row-open time (tRAS). A read raises a one-cycle data strobe CL cycles after its read command. Each access also produces a report on the cycle of its column command. The report gives the access class and the number of cycles from acceptance to first data: CL for a hit, tRCD+CL for an empty bank, and tRP+tRCD+CL for a miss.

Top module: `dram_bank_sequencer`

## Requirements
- R1: While reset is held and right after it is released, `cmd_code` is NOP, no row is open, `req_ready` is high, and `rd_valid` and `acc_valid` are low.
- R2: Commands are encoded as NOP=0, ACT=1, RD=2, WR=3 and PRE=4. ACT drives the row being opened on `cmd_row`. RD and WR drive the request's column on `cmd_col`. NOP is driven on every cycle that carries no command.
- R3: A request to a bank with no open row produces ACT in the first cycle after the accepting clock edge. The RD or WR follows exactly tRCD cycles after the ACT.
- R4: A request to the open row produces its RD or WR in the first cycle after the accepting edge. Such requests held valid on successive cycles yield one column command per cycle.
- R5: A request to a different row produces PRE first. ACT follows exactly tRP cycles after the PRE, and the column command follows tRCD cycles after that ACT.
- R6: PRE never comes earlier than tRAS cycles after the latest ACT. While tRAS is pending, `req_ready` is low for a request to another row and high for a request to the open row.
- R7: `rd_valid` is high for one cycle exactly CL cycles after each RD. A WR produces no strobe.
- R8: `acc_valid` pulses once per request, on the cycle of its column command. `acc_class` is 0 for a hit, 1 for an empty bank and 2 for a miss. For a read, `acc_latency` is CL, tRCD+CL or tRP+tRCD+CL. For a write, it is 0, tRCD or tRP+tRCD.
- R9: The timing inputs are captured only at request acceptance. Changing them during a sequence has no effect on that sequence.
- R10: A timing input of 0 behaves as 1.
- R11: `req_ready` stays low from the acceptance of an empty or miss request until its column command is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_cl | input | TW | Read latency in cycles |
| cfg_trcd | input | TW | Activate-to-column gap in cycles |
| cfg_trp | input | TW | Precharge recovery in cycles |
| cfg_tras | input | TW | Minimum activate-to-precharge time in cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | RW | Request row address |
| req_col | input | CW | Request column address |
| cmd_code | output | 3 | Command to the bank |
| cmd_row | output | RW | Row address for ACT and PRE, open row for RD and WR |
| cmd_col | output | CW | Column address for RD and WR |
| rd_valid | output | 1 | Read data strobe |
| acc_valid | output | 1 | Access report valid |
| acc_class | output | 2 | Hit, empty or miss |
| acc_latency | output | TW+2 | Cycles from acceptance to first data |

## Verification
On every cycle, the in-line properties check the spacing of commands against the captured tRCD, tRP and tRAS values. They also check that a column command only reaches an open row, that an activate never hits an already open bank, and that a report only accompanies a column command. Only the bench scenarios can show the exact cycle of each command, the latency values and class codes, the position of the read strobe, capture of the timing inputs at acceptance, the clamping of zero to one, and back-to-back hits on successive cycles.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } dbs_cmd_e;

  typedef enum logic [1:0] {
    ACC_HIT   = 2'd0,
    ACC_EMPTY = 2'd1,
    ACC_MISS  = 2'd2
  } dbs_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TRP  = 2'd1,
    ST_TRCD = 2'd2
  } dbs_st_e;

endpackage

// File: rtl/dbs_timer.sv
module dbs_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val - TW'(1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

  // R10: callers clamp zero to one before loading
  a_r10_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

  // R6: an expired window stays expired until reloaded
  a_r6_expired_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> done);

endmodule

// File: rtl/dbs_row_track.sv
module dbs_row_track
  import dbs_pkg::*;
#(
  parameter int RW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_en,
  input  logic          close_en,
  input  logic [RW-1:0] open_row_in,
  input  logic [RW-1:0] probe_row,
  output logic          open_vld,
  output logic [RW-1:0] open_row,
  output logic [1:0]    probe_cls
);

  logic          vld_q, vld_d;
  logic [RW-1:0] row_q, row_d;

  always_comb begin
    vld_d = vld_q;
    row_d = row_q;
    if (close_en) vld_d = 1'b0;
    if (open_en) begin
      vld_d = 1'b1;
      row_d = open_row_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      row_q <= '0;
    end else begin
      vld_q <= vld_d;
      row_q <= row_d;
    end
  end

  always_comb begin
    if (!vld_q)                  probe_cls = ACC_EMPTY;
    else if (row_q == probe_row) probe_cls = ACC_HIT;
    else                         probe_cls = ACC_MISS;
  end

  assign open_vld = vld_q;
  assign open_row = row_q;

  // R5: a row is opened only on a closed bank
  a_r5_open_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    open_en |-> !vld_q);

  // R5: a precharge only closes a row that is open
  a_r5_close_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    close_en |-> vld_q);

  // R5: opening and closing never share a cycle
  a_r5_open_close_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_en && close_en));

endmodule

// File: rtl/dbs_rd_pipe.sv
module dbs_rd_pipe #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [TW-1:0] lat,
  output logic          strobe
);

  localparam int DEPTH = (1 << TW) - 1;

  logic [DEPTH:0] pipe_q, pipe_d;

  always_comb begin
    pipe_d = pipe_q >> 1;
    if (launch) pipe_d[lat] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign strobe = pipe_q[0];

  // R7: a zero delay would put the strobe on the read cycle itself
  a_r7_launch_delay: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (lat != '0));

endmodule

// File: rtl/dram_bank_sequencer.sv
module dram_bank_sequencer
  import dbs_pkg::*;
#(
  parameter int RW = 14,
  parameter int CW = 10,
  parameter int TW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cfg_cl,
  input  logic [TW-1:0]     cfg_trcd,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [TW-1:0]     cfg_tras,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [RW-1:0]     req_row,
  input  logic [CW-1:0]     req_col,
  output logic [2:0]        cmd_code,
  output logic [RW-1:0]     cmd_row,
  output logic [CW-1:0]     cmd_col,
  output logic              rd_valid,
  output logic              acc_valid,
  output logic [1:0]        acc_class,
  output logic [TW+1:0]     acc_latency
);

  localparam int LW = TW + 2;

  dbs_st_e       st_q, st_d;
  logic          accept;

  logic [TW-1:0] cl_in, trcd_in, trp_in, tras_in;
  logic [TW-1:0] cl_q, trcd_q, trp_q, tras_q;
  logic [TW-1:0] cl_u, trcd_u, trp_u, tras_u;

  logic          pend_wr_q;
  logic [RW-1:0] pend_row_q;
  logic [CW-1:0] pend_col_q;
  logic [1:0]    pend_cls_q;
  logic [LW-1:0] el_q, el_d;

  logic          open_vld;
  logic [RW-1:0] open_row;
  logic [1:0]    probe_cls;

  logic          wait_load, wait_done, ras_done;
  logic [TW-1:0] wait_val;
  logic          act_go, pre_go, col_go, col_wr, rd_launch;
  logic [RW-1:0] act_row;
  logic [CW-1:0] col_col;
  logic [LW-1:0] col_off;

  logic [2:0]    cmd_d, cmd_q;
  logic [RW-1:0] cmd_row_d, cmd_row_q;
  logic [CW-1:0] cmd_col_d, cmd_col_q;
  logic          acc_valid_d, acc_valid_q;
  logic [1:0]    acc_cls_d, acc_cls_q;
  logic [LW-1:0] acc_lat_d, acc_lat_q;

  // ---------------- parameter clamp and selection ----------------
  always_comb begin
    cl_in   = (cfg_cl   == '0) ? TW'(1) : cfg_cl;
    trcd_in = (cfg_trcd == '0) ? TW'(1) : cfg_trcd;
    trp_in  = (cfg_trp  == '0) ? TW'(1) : cfg_trp;
    tras_in = (cfg_tras == '0) ? TW'(1) : cfg_tras;
  end

  assign req_ready = (st_q == ST_IDLE) &&
                     !(open_vld && (req_row != open_row) && !ras_done);
  assign accept    = req_valid && req_ready;

  always_comb begin
    cl_u   = accept ? cl_in   : cl_q;
    trcd_u = accept ? trcd_in : trcd_q;
    trp_u  = accept ? trp_in  : trp_q;
    tras_u = accept ? tras_in : tras_q;
  end

  // ---------------- sequencing ----------------
  always_comb begin
    st_d      = st_q;
    act_go    = 1'b0;
    pre_go    = 1'b0;
    col_go    = 1'b0;
    act_row   = pend_row_q;
    col_wr    = pend_wr_q;
    col_col   = pend_col_q;
    col_off   = el_q;
    acc_cls_d = pend_cls_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          acc_cls_d = probe_cls;
          if (probe_cls == ACC_HIT) begin
            col_go  = 1'b1;
            col_wr  = req_write;
            col_col = req_col;
            col_off = '0;
          end else if (probe_cls == ACC_EMPTY) begin
            act_go  = 1'b1;
            act_row = req_row;
            st_d    = ST_TRCD;
          end else begin
            pre_go  = 1'b1;
            st_d    = ST_TRP;
          end
        end
      end
      ST_TRP: begin
        if (wait_done) begin
          act_go = 1'b1;
          st_d   = ST_TRCD;
        end
      end
      ST_TRCD: begin
        if (wait_done) begin
          col_go = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd_d       = CMD_NOP;
    cmd_row_d   = '0;
    cmd_col_d   = '0;
    wait_load   = 1'b0;
    wait_val    = trcd_u;
    acc_valid_d = 1'b0;
    acc_lat_d   = '0;
    rd_launch   = 1'b0;
    if (act_go) begin
      cmd_d     = CMD_ACT;
      cmd_row_d = act_row;
      wait_load = 1'b1;
      wait_val  = trcd_u;
    end
    if (pre_go) begin
      cmd_d     = CMD_PRE;
      cmd_row_d = open_row;
      wait_load = 1'b1;
      wait_val  = trp_u;
    end
    if (col_go) begin
      cmd_d       = col_wr ? CMD_WR : CMD_RD;
      cmd_row_d   = open_row;
      cmd_col_d   = col_col;
      acc_valid_d = 1'b1;
      acc_lat_d   = col_off + (col_wr ? LW'(0) : LW'(cl_u));
      rd_launch   = !col_wr;
    end
  end

  assign el_d = accept ? LW'(1) : ((el_q == '1) ? el_q : el_q + LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cl_q        <= TW'(1);
      trcd_q      <= TW'(1);
      trp_q       <= TW'(1);
      tras_q      <= TW'(1);
      pend_wr_q   <= 1'b0;
      pend_row_q  <= '0;
      pend_col_q  <= '0;
      pend_cls_q  <= '0;
      el_q        <= '0;
      cmd_q       <= CMD_NOP;
      cmd_row_q   <= '0;
      cmd_col_q   <= '0;
      acc_valid_q <= 1'b0;
      acc_cls_q   <= '0;
      acc_lat_q   <= '0;
    end else begin
      st_q <= st_d;
      el_q <= el_d;
      if (accept) begin
        cl_q       <= cl_in;
        trcd_q     <= trcd_in;
        trp_q      <= trp_in;
        tras_q     <= tras_in;
        pend_wr_q  <= req_write;
        pend_row_q <= req_row;
        pend_col_q <= req_col;
        pend_cls_q <= probe_cls;
      end
      cmd_q       <= cmd_d;
      cmd_row_q   <= cmd_row_d;
      cmd_col_q   <= cmd_col_d;
      acc_valid_q <= acc_valid_d;
      if (acc_valid_d) begin
        acc_cls_q <= acc_cls_d;
        acc_lat_q <= acc_lat_d;
      end
    end
  end

  // ---------------- sub-blocks ----------------
  dbs_row_track #(.RW(RW)) i_row_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_en     (act_go),
    .close_en    (pre_go),
    .open_row_in (act_row),
    .probe_row   (req_row),
    .open_vld    (open_vld),
    .open_row    (open_row),
    .probe_cls   (probe_cls)
  );

  dbs_timer #(.TW(TW)) i_wait_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wait_load),
    .load_val (wait_val),
    .done     (wait_done)
  );

  dbs_timer #(.TW(TW)) i_ras_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (act_go),
    .load_val (tras_u),
    .done     (ras_done)
  );

  dbs_rd_pipe #(.TW(TW)) i_rd_pipe (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (rd_launch),
    .lat    (cl_u),
    .strobe (rd_valid)
  );

  assign cmd_code    = cmd_q;
  assign cmd_row     = cmd_row_q;
  assign cmd_col     = cmd_col_q;
  assign acc_valid   = acc_valid_q;
  assign acc_class   = acc_cls_q;
  assign acc_latency = acc_lat_q;

  // ---------------- command spacing checks ----------------
  logic [LW-1:0] since_act_q, since_pre_q;
  logic [TW-1:0] chk_trcd_q, chk_tras_q, chk_trp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act_q <= '1;
      since_pre_q <= '1;
      chk_trcd_q  <= '0;
      chk_tras_q  <= '0;
      chk_trp_q   <= '0;
    end else begin
      if (cmd_code == CMD_ACT) begin
        since_act_q <= LW'(1);
        chk_trcd_q  <= trcd_q;
        chk_tras_q  <= tras_q;
      end else if (since_act_q != '1) begin
        since_act_q <= since_act_q + LW'(1);
      end
      if (cmd_code == CMD_PRE) begin
        since_pre_q <= LW'(1);
        chk_trp_q   <= trp_q;
      end else if (since_pre_q != '1) begin
        since_pre_q <= since_pre_q + LW'(1);
      end
    end
  end

  // R3: column command no sooner than tRCD after the activate
  a_r3_act_to_col: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_RD || cmd_code == CMD_WR) |-> (since_act_q >= LW'(chk_trcd_q)));

  // R5: activate no sooner than tRP after a precharge
  a_r5_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_ACT) |-> (since_pre_q >= LW'(chk_trp_q)));

  // R6: precharge no sooner than tRAS after the activate
  a_r6_act_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |-> (since_act_q >= LW'(chk_tras_q)));

  // R2: column commands only reach an open row
  a_r2_col_needs_row: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_RD || cmd_code == CMD_WR) |-> open_vld);

  // R8: a report travels with a column command
  a_r8_report_on_col: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (cmd_code == CMD_RD || cmd_code == CMD_WR));

endmodule

// File: tb/test_dram_bank_sequencer.sv
module test_dram_bank_sequencer;

  localparam int RW = 14;
  localparam int CW = 10;
  localparam int TW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] cfg_cl = 6'd3, cfg_trcd = 6'd3, cfg_trp = 6'd3, cfg_tras = 6'd10;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic [2:0]    cmd_code;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic          rd_valid;
  logic          acc_valid;
  logic [1:0]    acc_class;
  logic [TW+1:0] acc_latency;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int act_cyc = 0;
  int pre_cyc = 0;
  bit finished = 1'b0;

  // {write, row[13:0], col[9:0], class[1:0], latency[7:0]} with CL=tRCD=tRP=3, tRAS=10
  localparam logic [34:0] VEC [8] = '{
    {1'b0, 14'd5, 10'd1, 2'd1, 8'd6},
    {1'b0, 14'd5, 10'd2, 2'd0, 8'd3},
    {1'b1, 14'd5, 10'd3, 2'd0, 8'd0},
    {1'b0, 14'd9, 10'd4, 2'd2, 8'd9},
    {1'b1, 14'd9, 10'd5, 2'd0, 8'd0},
    {1'b1, 14'd2, 10'd6, 2'd2, 8'd6},
    {1'b0, 14'd2, 10'd7, 2'd0, 8'd3},
    {1'b0, 14'd7, 10'd8, 2'd2, 8'd9}
  };

  dram_bank_sequencer #(.RW(RW), .CW(CW), .TW(TW)) i_dram_bank_sequencer (
    .clk(clk), .rst_n(rst_n),
    .cfg_cl(cfg_cl), .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_tras(cfg_tras),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_row(req_row), .req_col(req_col),
    .cmd_code(cmd_code), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rd_valid(rd_valid), .acc_valid(acc_valid), .acc_class(acc_class),
    .acc_latency(acc_latency)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (cmd_code == 3'd1) act_cyc = cyc;
    if (cmd_code == 3'd4) pre_cyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic set_cfg(input int cl, input int rcd, input int rp, input int ras);
    cfg_cl = TW'(cl); cfg_trcd = TW'(rcd); cfg_trp = TW'(rp); cfg_tras = TW'(ras);
  endtask

  // one request; checks first command, column cycle, report and strobe
  task automatic access(input bit w, input int row, input int col,
                        input int cls, input int lat, input int cl);
    int j;
    int first;
    int seen;
    string tag;
    tag   = (cls == 0) ? "R4" : ((cls == 1) ? "R3" : "R5");
    first = (cls == 0) ? (w ? 3 : 2) : ((cls == 1) ? 1 : 4);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_row = RW'(row); req_col = CW'(col);
    #1;
    j = 0;
    while (!req_ready && j < 500) begin
      @(negedge clk); #1; j++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(int'(cmd_code) == first, tag, int'(cmd_code), first);
    if (cls == 1) chk(int'(cmd_row) == row, "R2", int'(cmd_row), row);
    j = 0;
    while (!acc_valid && j < 300) begin
      @(negedge clk); j++;
    end
    chk(j == lat - (w ? 0 : cl), tag, j, lat - (w ? 0 : cl));
    chk(int'(cmd_code) == (w ? 3 : 2), "R2", int'(cmd_code), w ? 3 : 2);
    chk(int'(cmd_col) == col, "R2", int'(cmd_col), col);
    chk(int'(acc_class) == cls, "R8", int'(acc_class), cls);
    chk(int'(acc_latency) == lat, "R8", int'(acc_latency), lat);
    if (!w) begin
      if (cl > 1) begin
        repeat (cl - 1) @(negedge clk);
        chk(rd_valid == 1'b0, "R7", int'(rd_valid), 0);
      end
      @(negedge clk);
      chk(rd_valid == 1'b1, "R7", int'(rd_valid), 1);
    end else begin
      seen = 0;
      repeat (cl + 1) begin
        @(negedge clk);
        if (rd_valid) seen++;
      end
      chk(seen == 0, "R7", seen, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int j;
    int saved;
    int cnt;

    // R1: reset state
    @(negedge clk);
    #1;
    chk(cmd_code == 3'd0, "R1", int'(cmd_code), 0);
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
    do_reset();
    chk(cmd_code == 3'd0, "R1", int'(cmd_code), 0);
    chk(req_ready == 1'b1, "R1", int'(req_ready), 1);
    chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
    chk(acc_valid == 1'b0, "R1", int'(acc_valid), 0);
    repeat (3) begin
      @(negedge clk);
      chk(cmd_code == 3'd0, "R2", int'(cmd_code), 0);
    end

    // table of accesses at 3-3-3-10
    set_cfg(3, 3, 3, 10);
    for (int i = 0; i < 8; i++) begin
      access(VEC[i][34], int'(VEC[i][33:20]), int'(VEC[i][19:10]),
             int'(VEC[i][9:8]), int'(VEC[i][7:0]), 3);
    end

    // R6: tRAS holds off a miss but not a hit
    do_reset();
    set_cfg(3, 3, 3, 12);
    access(1'b0, 1, 0, 1, 6, 3);
    @(negedge clk);
    req_valid = 1'b0; req_row = RW'(1);
    #1;
    chk(req_ready == 1'b1, "R6", int'(req_ready), 1);
    req_row = RW'(2);
    #1;
    chk(req_ready == 1'b0, "R6", int'(req_ready), 0);
    saved = act_cyc;
    access(1'b0, 2, 5, 2, 9, 3);
    chk(pre_cyc - saved == 12, "R6", pre_cyc - saved, 12);

    // R9 and R11: timing captured at acceptance, ready low during sequence
    do_reset();
    set_cfg(2, 4, 3, 10);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_row = RW'(3); req_col = CW'(9);
    #1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_cl = 6'd7; cfg_trcd = 6'd1;
    #1;
    chk(cmd_code == 3'd1, "R3", int'(cmd_code), 1);
    chk(req_ready == 1'b0, "R11", int'(req_ready), 0);
    j = 0;
    while (cmd_code != 3'd2 && j < 50) begin
      @(negedge clk); j++;
      if (j == 2) chk(req_ready == 1'b0, "R11", int'(req_ready), 0);
    end
    chk(j == 4, "R9", j, 4);
    chk(int'(acc_latency) == 6, "R9", int'(acc_latency), 6);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R9", int'(rd_valid), 0);
    @(negedge clk);
    chk(rd_valid == 1'b1, "R9", int'(rd_valid), 1);

    // R10: zero timing inputs behave as one
    do_reset();
    set_cfg(0, 0, 0, 0);
    access(1'b0, 4, 1, 1, 2, 1);
    access(1'b0, 6, 2, 2, 3, 1);
    access(1'b1, 6, 3, 0, 0, 1);
    chk(1'b1, "R10", 0, 0);

    // R4 and R7: back-to-back hits, one strobe each
    do_reset();
    set_cfg(3, 3, 3, 10);
    access(1'b0, 8, 0, 1, 6, 3);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_row = RW'(8); req_col = CW'(20);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk(cmd_code == 3'd2, "R4", int'(cmd_code), 2);
      chk(int'(cmd_col) == 20 + k, "R4", int'(cmd_col), 20 + k);
      if (rd_valid) cnt++;
      if (k == 3) req_valid = 1'b0;
      else req_col = CW'(21 + k);
    end
    repeat (6) begin
      @(negedge clk);
      if (rd_valid) cnt++;
    end
    chk(cnt == 4, "R7", cnt, 4);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule